// File: doc/BRIEF.md
# Dual-Alignment PWM Channel Timebase

This block is the timebase of one pulse-width-modulated output. A 16-bit channel counter advances on a one-cycle count enable. That enable comes from one of three places: a free-running power-of-two prescaler with eleven divide steps, or either of two independent linear dividers. All three stay in the single system clock domain. In left-aligned mode the counter climbs and wraps to zero. In center-aligned mode it climbs to the period value and falls back to zero, so the same settings give twice the output period.

The output is driven high while the counter is below the duty value. The period, duty and alignment inputs are captured into working copies only when a period ends, so a value changed mid-period never cuts a pulse short. A single-cycle event marks the start of every period. A zero period parks the channel: the counter stays at zero, the output stays low, and no events are produced.

Top module: `pwm_chan_timebase`

## Requirements
- R1: Only bits 15:0 of the 32-bit `period_i` are used; a value whose upper half is nonzero behaves exactly like its low half.
- R2: With `src_i` equal to 2'b00 or 2'b11, the counter advances once every 2^k clock cycles, where k is `pre_i` for values 0 to 10, and any `pre_i` above 10 acts as 10 (divide by 1024).
- R3: With `src_i` = 2'b01 (divider A) or 2'b10 (divider B), the counter advances once every N cycles, where N is `div_a_i` or `div_b_i`; N = 0 stops the counter, so no period event occurs.
- R4: In left-aligned mode (`center_i` = 0), period events are F*P cycles apart, where F is the divide factor and P the period value.
- R5: In center-aligned mode (`center_i` = 1), period events are 2*F*P cycles apart.
- R6: For 0 < D < P, the output is high for F*D cycles per period in left-aligned mode and for F*(2D-1) cycles in center-aligned mode, where D is `duty_i`.
- R7: D = 0 keeps the output low for the whole period; D >= P keeps it high for the whole period, in both modes.
- R8: A change of period, duty or mode made during a period takes effect only at the next period event; the running period keeps its old length.
- R9: While the working period is zero, the counter holds at zero, `pwm_o` is low and no event occurs; a nonzero period is then picked up on the next clock edge.
- R10: `period_evt_o` is high for exactly one cycle, the first cycle in which the counter holds zero after a wrap or after returning from its peak.
- R11: During and right after reset, `pwm_o` and `period_evt_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 32 | Period value; only the low 16 bits are used |
| duty_i | input | 16 | Duty compare value |
| center_i | input | 1 | 1 = center-aligned, 0 = left-aligned |
| src_i | input | 2 | Count enable source: 00/11 prescaler, 01 divider A, 10 divider B |
| pre_i | input | 4 | Prescaler step k (divide by 2^k, clamped at 10) |
| div_a_i | input | 8 | Divide factor of divider A (0 = stopped) |
| div_b_i | input | 8 | Divide factor of divider B (0 = stopped) |
| pwm_o | output | 1 | PWM waveform |
| period_evt_o | output | 1 | One-cycle pulse at each period start |

## Verification
Period events are registered, so they rise one clock edge after the count enable that closes a period. `pwm_o` is a compare of registered state and follows the counter in that same cycle. Working copies load on the edge that raises the event, so a new setting first shapes the period that begins with that event. The bench samples at the falling edge and measures each period from one event to the next. It counts cycles and high cycles. After any change of settings it waits out three events before it arms a measurement, which lets the prescaler phase and the working copies settle. The shadow and idle cases count cycles directly from the event at which the input was changed.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    SRC_PRE  = 2'b00,
    SRC_DIVA = 2'b01,
    SRC_DIVB = 2'b10,
    SRC_PRE2 = 2'b11
  } src_e;

  // Output level for a counter value against the working duty and period.
  function automatic logic level_at(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] duty,
                                    input logic [CNT_W-1:0] per);
    return (per != '0) && ((duty >= per) || (cnt < duty));
  endfunction

  // True when cnt+1 reaches per (the top of an up-count).
  function automatic logic reaches_top(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] per);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, per};
  endfunction

  // Clamp a prescaler step to the largest available tap.
  function automatic int unsigned clamp_step(input int unsigned s,
                                             input int unsigned top);
    return (s > top) ? top : s;
  endfunction
endpackage

// File: rtl/pwm_pow2_prescaler.sv
module pwm_pow2_prescaler #(
  parameter int STEPS = 11,
  parameter int SEL_W = 4,
  localparam int DIV_W = STEPS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] free_q;
  logic [STEPS-1:0] taps;
  int unsigned      step;

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '0;
    else        free_q <= free_q + 1'b1;
  end

  assign taps[0] = 1'b1;
  for (genvar k = 1; k < STEPS; k++) begin : g_tap
    assign taps[k] = &free_q[k-1:0];
  end

  always_comb begin
    step = pwm_tbase_pkg::clamp_step(int'(sel), STEPS - 1);
    tick = taps[step];
  end

  // R2: above divide-by-1 a tick never repeats on the next cycle
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/pwm_lin_divider.sv
module pwm_lin_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] factor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (factor != '0) && ({1'b0, cnt_q} + 1'b1 >= {1'b0, factor});
  assign tick   = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (factor == '0)   cnt_q <= '0;
    else if (at_end)         cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R3: a zero factor stops the divider
  a_r3_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (factor == '0) |-> !tick);
endmodule

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt #(
  parameter int CNT_W = pwm_tbase_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_new,
  input  logic [CNT_W-1:0] duty_new,
  input  logic             center_new,
  output logic             pwm,
  output logic             evt
);
  logic [CNT_W-1:0] cnt_q, per_q, duty_q;
  logic             center_q, down_q, evt_q;
  logic             idle, wrap_now, up_top;

  assign idle     = (per_q == '0);
  assign up_top   = pwm_tbase_pkg::reaches_top(cnt_q, per_q);
  assign wrap_now = center_q ? (down_q && cnt_q <= 1) : up_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_q    <= '0;
      duty_q   <= '0;
      center_q <= 1'b0;
      down_q   <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (idle) begin
        per_q    <= per_new;
        duty_q   <= duty_new;
        center_q <= center_new;
        cnt_q    <= '0;
        down_q   <= 1'b0;
      end else if (tick) begin
        if (wrap_now) begin
          cnt_q    <= '0;
          down_q   <= 1'b0;
          evt_q    <= 1'b1;
          per_q    <= per_new;
          duty_q   <= duty_new;
          center_q <= center_new;
        end else if (!center_q) begin
          cnt_q <= cnt_q + 1'b1;
        end else if (!down_q) begin
          if (up_top) begin
            cnt_q  <= per_q;
            down_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pwm = pwm_tbase_pkg::level_at(cnt_q, duty_q, per_q);
  assign evt = evt_q;

  // R10: an event only ever appears with the counter at zero
  a_r10_evt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (cnt_q == '0));
  // R9: an idle channel stays parked and silent
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt_q == '0 && !evt_q));
  // R8: a running period changes only together with an event
  a_r8_shadow_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(per_q) != '0 && per_q != $past(per_q)) |-> evt_q);
  // R5: the counter never passes the working period
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |-> (cnt_q <= per_q));
  // R11: reset leaves the waveform low
  a_r11_reset_low: assert property (@(posedge clk)
    $past(!rst_n) |-> (!pwm && !evt_q));
endmodule

// File: rtl/pwm_chan_timebase.sv
module pwm_chan_timebase #(
  parameter int PER_W     = 32,
  parameter int CNT_W     = pwm_tbase_pkg::CNT_W,
  parameter int PRE_STEPS = 11,
  parameter int PRE_SEL_W = 4,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PER_W-1:0]     period_i,
  input  logic [CNT_W-1:0]     duty_i,
  input  logic                 center_i,
  input  logic [1:0]           src_i,
  input  logic [PRE_SEL_W-1:0] pre_i,
  input  logic [DIV_W-1:0]     div_a_i,
  input  logic [DIV_W-1:0]     div_b_i,
  output logic                 pwm_o,
  output logic                 period_evt_o
);
  import pwm_tbase_pkg::*;
  localparam int NDIV = 2;

  logic              tick_pre, tick_sel;
  logic [NDIV-1:0]   tick_div;
  logic [DIV_W-1:0]  div_fac [NDIV];
  logic [CNT_W-1:0]  per_used;

  assign div_fac[0] = div_a_i;
  assign div_fac[1] = div_b_i;
  assign per_used   = period_i[CNT_W-1:0];

  pwm_pow2_prescaler #(.STEPS(PRE_STEPS), .SEL_W(PRE_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(pre_i), .tick(tick_pre)
  );

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    pwm_lin_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .factor(div_fac[i]), .tick(tick_div[i])
    );
  end

  always_comb begin
    unique case (src_e'(src_i))
      SRC_DIVA: tick_sel = tick_div[0];
      SRC_DIVB: tick_sel = tick_div[1];
      default:  tick_sel = tick_pre;
    endcase
  end

  pwm_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel),
    .per_new(per_used), .duty_new(duty_i), .center_new(center_i),
    .pwm(pwm_o), .evt(period_evt_o)
  );
endmodule

// File: tb/tb_pwm_chan_timebase.sv
module tb_pwm_chan_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] period_i = '0;
  logic [15:0] duty_i = '0;
  logic        center_i = 1'b0;
  logic [1:0]  src_i = 2'b00;
  logic [3:0]  pre_i = '0;
  logic [7:0]  div_a_i = '0;
  logic [7:0]  div_b_i = '0;
  logic        pwm_o, period_evt_o;

  typedef struct { int len; int hi; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit armed = 1'b0;
  int m_len = 0, m_hi = 0;

  always #5 clk = ~clk;

  pwm_chan_timebase dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .center_i(center_i), .src_i(src_i), .pre_i(pre_i),
    .div_a_i(div_a_i), .div_b_i(div_b_i),
    .pwm_o(pwm_o), .period_evt_o(period_evt_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: measure every period between events, compare when armed.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (period_evt_o) begin
          if (armed && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " period"}, m_len, e.len);
            check({e.tag, " high"}, m_hi, e.hi);
          end
          armed = (q.size() > 0);
          m_len = 0;
          m_hi  = 0;
        end
        m_len++;
        if (pwm_o) m_hi++;
      end
    end
  end

  task automatic wait_evts(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (period_evt_o) seen++;
    end
  endtask

  task automatic run_case(input logic [31:0] per, input logic [15:0] duty,
                          input logic ctr, input logic [1:0] src,
                          input logic [3:0] pre, input logic [7:0] da,
                          input logic [7:0] db, input int elen,
                          input int ehi, input string tag);
    exp_t e;
    @(negedge clk);
    period_i = per; duty_i = duty; center_i = ctr; src_i = src;
    pre_i = pre; div_a_i = da; div_b_i = db;
    wait_evts(3);
    e.len = elen; e.hi = ehi; e.tag = tag;
    q.push_back(e);
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic count_window(input int n, output int evts, output int highs);
    evts = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (period_evt_o) evts++;
      if (pwm_o) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c, ev, hi;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 pwm in reset", pwm_o, 0);
    check("R11 evt in reset", period_evt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 pwm after reset", pwm_o, 0);
    check("R11 evt after reset", period_evt_o, 0);

    run_case(32'd10, 16'd3, 1'b0, 2'b00, 4'd0, 8'd0, 8'd0, 10, 3, "R4 left div1");
    run_case(32'd5, 16'd2, 1'b0, 2'b00, 4'd3, 8'd0, 8'd0, 40, 16, "R2 left div8");
    run_case(32'd3, 16'd1, 1'b0, 2'b11, 4'd10, 8'd0, 8'd0, 3072, 1024, "R2 div1024");
    run_case(32'd2, 16'd1, 1'b0, 2'b00, 4'd15, 8'd0, 8'd0, 2048, 1024, "R2 clamp");
    run_case(32'd6, 16'd4, 1'b0, 2'b01, 4'd0, 8'd3, 8'd0, 18, 12, "R3 divA");
    run_case(32'd4, 16'd2, 1'b1, 2'b10, 4'd0, 8'd0, 8'd5, 40, 15, "R5 center divB");
    run_case(32'd3, 16'd1, 1'b1, 2'b00, 4'd1, 8'd0, 8'd0, 12, 2, "R5 center div2");
    run_case(32'd6, 16'd3, 1'b1, 2'b00, 4'd0, 8'd0, 8'd0, 12, 5, "R6 center duty");
    run_case(32'hFFFF_0006, 16'd2, 1'b0, 2'b00, 4'd0, 8'd0, 8'd0, 6, 2, "R1 upper ignored");
    run_case(32'd8, 16'd0, 1'b0, 2'b00, 4'd0, 8'd0, 8'd0, 8, 0, "R7 duty zero");
    run_case(32'd5, 16'd9, 1'b1, 2'b00, 4'd0, 8'd0, 8'd0, 10, 10, "R7 duty above");
    run_case(32'd5, 16'd5, 1'b1, 2'b00, 4'd0, 8'd0, 8'd0, 10, 10, "R7 duty equal");

    // R8: period change mid-period keeps the running period
    run_case(32'd10, 16'd3, 1'b0, 2'b00, 4'd0, 8'd0, 8'd0, 10, 3, "R8 setup");
    wait_evts(1);
    period_i = 32'd4;
    c = 0;
    do begin @(negedge clk); c++; end while (!period_evt_o);
    check("R8 old period kept", c, 10);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 1) check("R10 evt one cycle", period_evt_o, 0);
    end while (!period_evt_o);
    check("R8 new period used", c, 4);

    // R9: zero period parks the channel
    period_i = 32'd0; duty_i = 16'd5;
    wait_evts(1);
    count_window(200, ev, hi);
    check("R9 idle events", ev, 0);
    check("R9 idle high", hi, 0);
    period_i = 32'd7; duty_i = 16'd7;
    @(negedge clk);
    check("R9 restart pickup", pwm_o, 1);

    // R3: divider factor zero stops the count
    run_case(32'd4, 16'd2, 1'b0, 2'b01, 4'd0, 8'd2, 8'd0, 8, 4, "R3 divA pre-stop");
    div_a_i = 8'd0;
    count_window(300, ev, hi);
    check("R3 stopped events", ev, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule